// File: doc/BRIEF.md
# Dual-Port RAM with Collision Arbitration

This block is a clocked 2048 x 8 shared memory with two independent access ports, called left and right. Each port has its own enable, write select, output enable, address and data buses, so the two sides can reach any word in the same cycle. Typical uses are a mailbox or buffer between two agents, or a shared table that two engines read in parallel.

When both ports are enabled on the same word, an arbiter picks the port whose access was already in place. That port keeps the word. The other port sees an active-low busy flag, and its write is dropped. Reads always complete, including the loser's.

A mode input turns the block into a follower. In that mode the block does no arbitration of its own, and each port takes an external active-low busy input that blocks that port's write. Several instances can then share one arbitrating instance to build a wider word. Address and data widths come from constants in the shared package.

Top module: `dual_port_ram_arb`

## Requirements
- R1: The array holds 2048 words of 8 bits. A write on either port (enable high, write select high, not blocked) stores the write data at that port's 11-bit address, and a later read from either port returns it.
- R2: When a port has enable high, output enable high and write select low, its read data equals the word held before that cycle's writes, one clock later, with its valid output high.
- R3: In any other cycle, including write cycles and cycles with enable low, that port's valid output is low one clock later and its read data is 0.
- R4: Both ports may read the same word in the same cycle, and both return the stored data.
- R5: In arbitrating mode (follower input low), a port is "steady" when it was enabled on the same address in the previous cycle. When both ports are enabled on one address and only one port is steady, the other port's busy output goes low in that same cycle.
- R6: In arbitrating mode, when both ports land on a shared address and both are steady or neither is, the left port wins and the right busy output goes low.
- R7: While both ports stay steady on the shared address, the winner does not change. Both busy outputs are high in every cycle where the addresses differ or either port is disabled.
- R8: In arbitrating mode, a write from the port whose busy output is low is discarded, and a write from the winning port is stored.
- R9: In follower mode, both busy outputs stay high. A low external busy input discards that port's write, and reads on that port are not affected.
- R10: When both ports write one address in the same cycle and neither write is blocked, the left port's data is stored.
- R11: While reset is high and for the first cycle after it, both valid outputs are low, both read data buses are 0, and, with both ports disabled, both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| follower | input | 1 | 1: follower mode with external busy inputs; 0: arbitrating mode |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left write select (1 = write) |
| l_oe | input | 1 | Left output enable |
| l_addr | input | 11 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_busy_in_n | input | 1 | Left external busy, active low, used in follower mode |
| l_rdata | output | 8 | Left registered read data |
| l_rvalid | output | 1 | Left read data valid |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right write select (1 = write) |
| r_oe | input | 1 | Right output enable |
| r_addr | input | 11 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_busy_in_n | input | 1 | Right external busy, active low, used in follower mode |
| r_rdata | output | 8 | Right registered read data |
| r_rvalid | output | 1 | Right read data valid |
| r_busy_n | output | 1 | Right busy flag, active low |

## Verification
The hardest case to reach from the ports is a contested word whose owner was decided several cycles earlier. The winner then depends on history rather than on the current inputs: one side must settle on an address first, the other must move onto it later, both must hold, and the loser must try a write during the hold. Directed sequences build each ordering on purpose: left first, right first, simultaneous arrival, hold, then release. A random phase follows in which addresses are drawn from a set of three words and often kept from the previous cycle, so that contested words and held ownership occur often while the mode and the external busy inputs also change.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

    localparam int AW    = 11;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int NP    = 2;

    localparam logic [DW-1:0] IDLE_DATA = '0;

    typedef enum logic {
        SIDE_L = 1'b0,
        SIDE_R = 1'b1
    } side_e;

    typedef struct packed {
        logic          en;
        logic          we;
        logic          oe;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } req_t;

    typedef struct packed {
        logic          vld;
        logic [DW-1:0] data;
    } rsp_t;

    function automatic logic is_read(req_t r);
        return r.en && r.oe && !r.we;
    endfunction

    function automatic logic is_write(req_t r);
        return r.en && r.we;
    endfunction

    // Earlier arrival wins; a held contest keeps its owner; ties go left.
    function automatic side_e pick_winner(logic held, side_e owner,
                                          logic l_steady, logic r_steady);
        if (held)                  return owner;
        if (l_steady && !r_steady) return SIDE_L;
        if (r_steady && !l_steady) return SIDE_R;
        return SIDE_L;
    endfunction

endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
    import dpr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   master,
    input  logic [NP-1:0]          en,
    input  logic [NP-1:0][AW-1:0]  addr,
    output logic [NP-1:0]          busy
);

    logic [NP-1:0]         en_q;
    logic [NP-1:0][AW-1:0] addr_q;
    logic [NP-1:0]         steady;
    logic                  match;
    logic                  match_q;
    logic                  held;
    side_e                 owner_q;
    side_e                 winner;

    for (genvar g = 0; g < NP; g++) begin : g_steady
        assign steady[g] = en[g] && en_q[g] && (addr_q[g] == addr[g]);
    end

    assign match  = en[0] && en[1] && (addr[0] == addr[1]);
    assign held   = match_q && steady[0] && steady[1];
    assign winner = pick_winner(held, owner_q, steady[0], steady[1]);

    always_comb begin
        busy = '0;
        if (master && match) begin
            busy[0] = (winner == SIDE_R);
            busy[1] = (winner == SIDE_L);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            addr_q  <= '0;
            match_q <= 1'b0;
            owner_q <= SIDE_L;
        end else begin
            en_q    <= en;
            addr_q  <= addr;
            match_q <= match;
            if (match) owner_q <= winner;
        end
    end

    // R5: a newcomer to a settled word loses
    assert_late_left_loses_R5: assert property (@(posedge clk) disable iff (rst)
        (master && match && steady[1] && !steady[0]) |-> (busy == 2'b01));
    assert_late_right_loses_R5: assert property (@(posedge clk) disable iff (rst)
        (master && match && steady[0] && !steady[1]) |-> (busy == 2'b10));

    // R6: simultaneous arrival goes to the left port
    assert_tie_goes_left_R6: assert property (@(posedge clk) disable iff (rst)
        (master && match && !steady[0] && !steady[1]) |-> (busy == 2'b10));

    // R7: ownership persists while both hold
    assert_owner_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (master && $past(master) && match && steady[0] && steady[1] && $past(busy[0]))
        |-> busy[0]);

    // R7: no flag without a shared word
    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        !(en[0] && en[1] && (addr[0] == addr[1])) |-> (busy == '0));

endmodule

// File: rtl/dpr_write_gate.sv
module dpr_write_gate
    import dpr_pkg::*;
(
    input  logic          master,
    input  logic [NP-1:0] wr_req,
    input  logic [NP-1:0] arb_busy,
    input  logic [NP-1:0] ext_busy_n,
    output logic [NP-1:0] wr_en
);

    for (genvar g = 0; g < NP; g++) begin : g_gate
        logic blocked;
        assign blocked  = master ? arb_busy[g] : !ext_busy_n[g];
        assign wr_en[g] = wr_req[g] && !blocked;
    end

endmodule

// File: rtl/dpr_storage.sv
module dpr_storage
    import dpr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NP-1:0]          wr_en,
    input  logic [NP-1:0]          rd_en,
    input  logic [NP-1:0][AW-1:0]  addr,
    input  logic [NP-1:0][DW-1:0]  wdata,
    output logic [NP-1:0]          rvalid,
    output logic [NP-1:0][DW-1:0]  rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Highest port index first so that port 0 (left) lands last and wins.
    always_ff @(posedge clk) begin
        for (int i = NP - 1; i >= 0; i--) begin
            if (wr_en[i]) mem[addr[i]] <= wdata[i];
        end
    end

    for (genvar g = 0; g < NP; g++) begin : g_rd
        rsp_t q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '{vld: 1'b0, data: IDLE_DATA};
            end else if (rd_en[g]) begin
                q <= '{vld: 1'b1, data: mem[addr[g]]};
            end else begin
                q <= '{vld: 1'b0, data: IDLE_DATA};
            end
        end

        assign rvalid[g] = q.vld;
        assign rdata[g]  = q.data;

        // R2: a read request yields valid data on the next cycle
        assert_read_valid_R2: assert property (@(posedge clk) disable iff (rst)
            rd_en[g] |=> rvalid[g]);

        // R3: no read request leaves the output idle
        assert_idle_output_R3: assert property (@(posedge clk) disable iff (rst)
            !rd_en[g] |=> (!rvalid[g] && rdata[g] == IDLE_DATA));
    end

endmodule

// File: rtl/dual_port_ram_arb.sv
module dual_port_ram_arb
    import dpr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          follower,
    input  logic          l_en,
    input  logic          l_we,
    input  logic          l_oe,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    input  logic          l_busy_in_n,
    output logic [DW-1:0] l_rdata,
    output logic          l_rvalid,
    output logic          l_busy_n,
    input  logic          r_en,
    input  logic          r_we,
    input  logic          r_oe,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    input  logic          r_busy_in_n,
    output logic [DW-1:0] r_rdata,
    output logic          r_rvalid,
    output logic          r_busy_n
);

    req_t [NP-1:0]          req;
    logic [NP-1:0]          en_v;
    logic [NP-1:0]          wr_req;
    logic [NP-1:0]          rd_en;
    logic [NP-1:0]          wr_en;
    logic [NP-1:0]          busy;
    logic [NP-1:0]          ext_busy_n;
    logic [NP-1:0][AW-1:0]  addr_v;
    logic [NP-1:0][DW-1:0]  wdata_v;
    logic [NP-1:0]          rvalid_v;
    logic [NP-1:0][DW-1:0]  rdata_v;
    logic                   master;

    assign master = !follower;

    assign req[0] = '{en: l_en, we: l_we, oe: l_oe, addr: l_addr, wdata: l_wdata};
    assign req[1] = '{en: r_en, we: r_we, oe: r_oe, addr: r_addr, wdata: r_wdata};
    assign ext_busy_n = {r_busy_in_n, l_busy_in_n};

    for (genvar g = 0; g < NP; g++) begin : g_unpack
        assign en_v[g]    = req[g].en;
        assign addr_v[g]  = req[g].addr;
        assign wdata_v[g] = req[g].wdata;
        assign wr_req[g]  = is_write(req[g]);
        assign rd_en[g]   = is_read(req[g]);
    end

    dpr_arbiter i_arbiter (
        .clk    (clk),
        .rst    (rst),
        .master (master),
        .en     (en_v),
        .addr   (addr_v),
        .busy   (busy)
    );

    dpr_write_gate i_write_gate (
        .master     (master),
        .wr_req     (wr_req),
        .arb_busy   (busy),
        .ext_busy_n (ext_busy_n),
        .wr_en      (wr_en)
    );

    dpr_storage i_storage (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr_v),
        .wdata  (wdata_v),
        .rvalid (rvalid_v),
        .rdata  (rdata_v)
    );

    assign l_busy_n = !busy[0];
    assign r_busy_n = !busy[1];
    assign l_rvalid = rvalid_v[0];
    assign r_rvalid = rvalid_v[1];
    assign l_rdata  = rdata_v[0];
    assign r_rdata  = rdata_v[1];

    // R9: follower mode never drives a busy flag
    assert_follower_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        follower |-> (l_busy_n && r_busy_n));

    // R8: a flagged port never reaches the array
    assert_loser_write_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (master && !l_busy_n) |-> !wr_en[0]);

endmodule

// File: tb/test_dual_port_ram_arb.sv
module test_dual_port_ram_arb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       follower = 1'b0;
    logic       en   [2];
    logic       we   [2];
    logic       oe   [2];
    logic [10:0] addr [2];
    logic [7:0] wd   [2];
    logic       bin_n [2];
    logic [7:0] rdata [2];
    logic       rvalid [2];
    logic       busy_n [2];

    int n_tests = 0;
    int n_fail  = 0;

    // reference state
    logic [7:0]  ref_mem [2048];
    logic        p_en [2];
    logic [10:0] p_addr [2];
    logic        m_q;
    int          own_q;

    always #4 clk = ~clk;

    dual_port_ram_arb i_dual_port_ram_arb (
        .clk(clk), .rst(rst), .follower(follower),
        .l_en(en[0]), .l_we(we[0]), .l_oe(oe[0]), .l_addr(addr[0]), .l_wdata(wd[0]),
        .l_busy_in_n(bin_n[0]), .l_rdata(rdata[0]), .l_rvalid(rvalid[0]), .l_busy_n(busy_n[0]),
        .r_en(en[1]), .r_we(we[1]), .r_oe(oe[1]), .r_addr(addr[1]), .r_wdata(wd[1]),
        .r_busy_in_n(bin_n[1]), .r_rdata(rdata[1]), .r_rvalid(rvalid[1]), .r_busy_n(busy_n[1])
    );

    function automatic logic [7:0] pattern(int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic setp(input int p, input logic e, input logic w, input logic o,
                        input int a, input int d);
        en[p] = e; we[p] = w; oe[p] = o; addr[p] = 11'(a); wd[p] = 8'(d);
    endtask

    // Inputs are set just after a falling edge; returns at the next falling edge.
    task automatic tick(input string tag);
        logic ls, rs, match;
        int   win;
        logic eb [2];
        logic wr [2];
        logic rd [2];
        logic [7:0] ed [2];
        string bt;
        string dt;
        #1;
        ls    = p_en[0] && en[0] && (p_addr[0] == addr[0]);
        rs    = p_en[1] && en[1] && (p_addr[1] == addr[1]);
        match = en[0] && en[1] && (addr[0] == addr[1]);
        win   = (m_q && ls && rs) ? own_q : (ls && !rs) ? 0 : (rs && !ls) ? 1 : 0;
        eb[0] = !follower && match && (win == 1);
        eb[1] = !follower && match && (win == 0);
        bt = (tag != "") ? tag : (follower ? "R9" : "R5");
        chk(bt, "left busy_n",  int'(busy_n[0]), int'(!eb[0]));
        chk(bt, "right busy_n", int'(busy_n[1]), int'(!eb[1]));
        for (int p = 0; p < 2; p++) begin
            wr[p] = en[p] && we[p] && !(follower ? !bin_n[p] : eb[p]);
            rd[p] = en[p] && oe[p] && !we[p];
            ed[p] = ref_mem[addr[p]];
        end
        @(posedge clk);
        #1;
        if (wr[1]) ref_mem[addr[1]] = wd[1];
        if (wr[0]) ref_mem[addr[0]] = wd[0];
        for (int p = 0; p < 2; p++) begin
            dt = (tag != "") ? tag : (rd[p] ? "R2" : "R3");
            chk(dt, p == 0 ? "left rvalid" : "right rvalid", int'(rvalid[p]), int'(rd[p]));
            chk(dt, p == 0 ? "left rdata" : "right rdata", int'(rdata[p]),
                rd[p] ? int'(ed[p]) : 0);
            p_en[p]   = en[p];
            p_addr[p] = addr[p];
        end
        m_q = match;
        if (match) own_q = win;
        @(negedge clk);
    endtask

    task automatic idle2();
        setp(0, 0, 0, 0, 0, 0);
        setp(1, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        idle2();
        bin_n[0] = 1'b1; bin_n[1] = 1'b1;
        p_en[0] = 0; p_en[1] = 0; p_addr[0] = 0; p_addr[1] = 0;
        m_q = 0; own_q = 0;

        // R11: reset state
        repeat (3) @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            chk("R11", "rvalid in reset", int'(rvalid[p]), 0);
            chk("R11", "rdata in reset",  int'(rdata[p]), 0);
            chk("R11", "busy_n in reset", int'(busy_n[p]), 1);
        end
        rst = 1'b0;
        tick("R11");

        // fill the array: left even words, right odd words, no contest
        follower = 1'b1;
        for (int a = 0; a < 2048; a += 2) begin
            setp(0, 1, 1, 0, a,     pattern(a));
            setp(1, 1, 1, 0, a + 1, pattern(a + 1));
            tick("");
        end
        follower = 1'b0;
        idle2(); tick("");

        // R1: read back both ends of the array
        setp(0, 1, 0, 1, 0, 0); setp(1, 1, 0, 1, 2047, 0); tick("R1");
        setp(0, 1, 0, 1, 2047, 0); setp(1, 1, 0, 1, 1, 0); tick("R1");
        idle2(); tick("");

        // R6: both arrive on one word in the same cycle; R4 reads both succeed
        setp(0, 1, 0, 1, 100, 0); setp(1, 1, 0, 1, 100, 0); tick("R6");
        tick("R4");
        // R7: hold keeps left as owner, right write still dropped
        setp(1, 1, 1, 0, 100, 8'hA5); tick("R7");
        // R7: right moves away -> both flags released
        setp(1, 1, 0, 1, 101, 0); tick("R7");
        setp(0, 1, 0, 1, 100, 0); setp(1, 1, 0, 1, 100, 0); tick("R8");
        idle2(); tick("");

        // R5: left settles first, right arrives with a write -> right loses
        setp(0, 1, 0, 1, 200, 0); tick("R5");
        setp(1, 1, 1, 0, 200, 8'h3C); tick("R5");
        // R8: winner writes while loser holds
        setp(0, 1, 1, 0, 200, 8'hC3); tick("R8");
        setp(0, 1, 0, 1, 200, 0); setp(1, 0, 0, 0, 0, 0); tick("R8");
        idle2(); tick("");

        // R5: right settles first, left arrives with a write -> left loses
        setp(1, 1, 0, 1, 300, 0); tick("R5");
        setp(0, 1, 1, 0, 300, 8'h77); tick("R5");
        setp(0, 1, 0, 1, 300, 0); setp(1, 0, 0, 0, 0, 0); tick("R8");
        // R7: switching owner only after a release
        setp(1, 1, 0, 1, 300, 0); tick("R5");
        idle2(); tick("");

        // R3: write with output enable high gives no read data
        setp(0, 1, 1, 1, 400, 8'h12); setp(1, 1, 1, 1, 401, 8'h34); tick("R3");
        idle2(); tick("R3");

        // R9: follower mode, external busy blocks the left write only
        follower = 1'b1;
        bin_n[0] = 1'b0;
        setp(0, 1, 1, 0, 500, 8'hEE); setp(1, 1, 0, 1, 500, 0); tick("R9");
        bin_n[0] = 1'b1;
        setp(0, 1, 0, 1, 500, 0); setp(1, 1, 0, 1, 500, 0); tick("R9");
        // R10: both write the same word unblocked -> left data kept
        setp(0, 1, 1, 0, 600, 8'h5A); setp(1, 1, 1, 0, 600, 8'hA5); tick("R10");
        setp(0, 1, 0, 1, 600, 0); setp(1, 1, 0, 1, 600, 0); tick("R10");
        follower = 1'b0;
        idle2(); tick("");

        // random phase on a small address set
        for (int c = 0; c < 4000; c++) begin
            if (c % 64 == 0) follower = ($urandom_range(0, 3) == 0);
            for (int p = 0; p < 2; p++) begin
                int a;
                a = ($urandom_range(0, 1) == 0) ? int'(addr[p])
                                                : 700 + int'($urandom_range(0, 2));
                setp(p, $urandom_range(0, 9) < 8, $urandom_range(0, 9) < 4,
                     $urandom_range(0, 9) < 7, a, int'($urandom_range(0, 255)));
                bin_n[p] = $urandom_range(0, 4) != 0;
            end
            tick("");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule